// File: doc/BRIEF.md
# Microcoded March Memory Self-Test Sequencer

This block runs a March-type self-test over a word-wide RAM. A small program store holds 7-bit microwords, and each microword describes exactly one memory operation. Every operation in an element is applied to one location before the address moves on. Flags in each word mark whether it opens, continues or closes its element. When the closing word has run, the sequencer decides whether to jump back to the element's opening word for the next address, or to move on to the next element once the sweep is complete. This allows an element to hold any number of operations.

The store is preloaded with a 22-word March SS program. The test starts by itself when reset is released. The sequencer drives the RAM's test-side port with registered write and read strobes, an address and a solid data pattern. Read data returns one cycle after the read strobe, and each returned word is compared against the expected pattern. On a mismatch the block pulses a fault output carrying the failing address and the expected word, for a repair array to capture. When the sequencer fetches a word with the valid bit clear, it raises `done` and stops all memory traffic until the next reset.

Top module: `march_bist_ctrl`

## Requirements
- R1: While reset is low, `mem_we`, `mem_re`, `mem_addr`, `mem_wdata`, `done`, `fault`, `fault_addr` and `fault_exp` are all zero. After reset rises, the first access is a write of all zeros to address 0, and it is presented on the fourth rising clock edge.
- R2: The microword is decoded by bit position as follows: bit 6 valid (clear means end of test), bit 5 first operation, bit 4 in-between operation, bit 3 last operation, bit 2 descending address order, bit 1 write (clear means read), bit 0 all-ones pattern (clear means all zeros). The store holds W0; R0 R0 W0 R0 W1 ascending; R1 R1 W1 R1 W0 ascending; R0 R0 W0 R0 W1 descending; R1 R1 W1 R1 W0 descending; R0 ascending. It then holds end-of-test words.
- R3: Exactly one memory operation is issued per clock, with no idle cycle, from the first access to the last. All operations of an element are applied to one address before the address changes.
- R4: An ascending element sweeps the addresses from 0 up to the top address, and a descending element sweeps from the top address down to 0. Each element starts at its own first address, whatever the direction of the element before it.
- R5: `mem_wdata` carries the word's pattern, either all ones or all zeros, for writes and for reads alike. For a read this pattern is the expected data.
- R6: A read whose returned data differs from the expected pattern raises `fault` for one cycle. `fault_addr` and `fault_exp` then hold that read's address and expected word.
- R7: Reads that return the expected pattern never raise `fault`.
- R8: `done` rises in the same cycle as the final access. It then stays high until reset, and from the next cycle on no read or write strobe is issued.
- R9: `mem_we` and `mem_re` are never high in the same cycle.
- R10: `fault` is high exactly two cycles after the cycle in which the failing read strobe was high. `mem_rdata` is sampled one cycle after that strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_we | output | 1 | Write strobe to the RAM test port |
| mem_re | output | 1 | Read strobe to the RAM test port |
| mem_addr | output | ADDR_W | RAM word address |
| mem_wdata | output | DATA_W | Write data, or the expected data during a read |
| mem_rdata | input | DATA_W | RAM read data, valid the cycle after `mem_re` |
| done | output | 1 | End of test reached |
| fault | output | 1 | One-cycle pulse for a failing read |
| fault_addr | output | ADDR_W | Address of the failing read |
| fault_exp | output | DATA_W | Expected word of the failing read |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=8. A full March SS pass is then only 352 accesses, so every access of several complete runs can be compared against a reference list derived from the element definitions. The 16-location array lets the sweep reach both address ends, so the turn-around between ascending and descending elements and a stuck bit at the top address are both exercised. A reset in the middle of a run, and stuck-at-one and stuck-at-zero bits injected into the bench's RAM model, bring the fault counts, pulse addresses and pulse latency within reach.

// File: rtl/march_bist_pkg.sv
package march_bist_pkg;

  localparam int unsigned UWORD_W  = 7;
  localparam int unsigned PROG_LEN = 22;

  // bit 6 .. bit 0
  typedef struct packed {
    logic valid;
    logic first;
    logic mid;
    logic last;
    logic down;
    logic wr;
    logic ones;
  } uword_t;

  typedef enum logic [1:0] {
    SQ_LOAD = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_DONE = 2'd2
  } seq_state_t;

  // Program word at a given store index; indices past the program are end words.
  function automatic uword_t march_ss_word(input int unsigned idx);
    uword_t      w;
    int unsigned elem;
    int unsigned pos;
    w = '0;
    if (idx == 0) begin
      w = '{valid: 1'b1, first: 1'b1, mid: 1'b0, last: 1'b1,
            down: 1'b0, wr: 1'b1, ones: 1'b0};
    end else if (idx == PROG_LEN - 1) begin
      w = '{valid: 1'b1, first: 1'b1, mid: 1'b0, last: 1'b1,
            down: 1'b0, wr: 1'b0, ones: 1'b0};
    end else if (idx < PROG_LEN - 1) begin
      elem    = (idx - 1) / 5;
      pos     = (idx - 1) % 5;
      w.valid = 1'b1;
      w.first = (pos == 0);
      w.last  = (pos == 4);
      w.mid   = (pos != 0) && (pos != 4);
      w.down  = (elem >= 2);
      w.wr    = (pos == 2) || (pos == 4);
      w.ones  = ((elem % 2) == 0) ? (pos == 4) : (pos != 4);
    end
    return w;
  endfunction

endpackage

// File: rtl/march_ucode_store.sv
module march_ucode_store
  import march_bist_pkg::*;
#(
  parameter int unsigned IPW = 5
) (
  input  logic [IPW-1:0] rd_addr,
  output uword_t         rd_word
);

  localparam int unsigned DEPTH = 1 << IPW;

  uword_t tbl [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    assign tbl[gi] = march_ss_word(gi);
  end

  assign rd_word = tbl[rd_addr];

endmodule

// File: rtl/march_seq.sv
module march_seq
  import march_bist_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned IPW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [IPW-1:0]    fetch_addr,
  input  uword_t            fetch_word,
  output logic              issue,
  output logic              op_wr,
  output logic              op_ones,
  output logic [ADDR_W-1:0] op_addr,
  output logic              done
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

  seq_state_t        state_q, state_n;
  logic [IPW-1:0]    ip_q, ip_n;
  logic [IPW-1:0]    base_q, base_n;
  uword_t            ir_q, ir_n;
  logic [ADDR_W-1:0] addr_q, addr_n;

  logic ld, run;
  logic ip_en, ir_en, base_en, addr_en;
  logic at_end, wrap, hold;
  logic [ADDR_W-1:0] step_addr, start_addr;

  always_comb begin
    ld         = (state_q == SQ_LOAD);
    run        = (state_q == SQ_RUN);
    at_end     = ir_q.down ? (addr_q == '0) : (addr_q == ADDR_TOP);
    wrap       = ir_q.last && !at_end;
    hold       = ir_q.mid || (ir_q.first && !ir_q.last);
    step_addr  = ir_q.down ? (addr_q - 1'b1) : (addr_q + 1'b1);

    if (ld)        fetch_addr = ip_q;
    else if (wrap) fetch_addr = base_q;
    else           fetch_addr = ip_q + 1'b1;

    start_addr = fetch_word.down ? ADDR_TOP : '0;

    ip_en   = run;
    ip_n    = fetch_addr;
    ir_en   = ld || run;
    ir_n    = fetch_word;
    base_en = (ld || run) && fetch_word.first;
    base_n  = fetch_addr;
    addr_en = ld || (run && !hold);
    addr_n  = (ld || at_end) ? start_addr : step_addr;

    state_n = state_q;
    if (ld || run) state_n = fetch_word.valid ? SQ_RUN : SQ_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_LOAD;
    else        state_q <= state_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ip_q <= '0;
    else if (ip_en) ip_q <= ip_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir_q <= '0;
    else if (ir_en) ir_q <= ir_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_n;
  end

  assign issue   = run && ir_q.valid;
  assign op_wr   = ir_q.wr;
  assign op_ones = ir_q.ones;
  assign op_addr = addr_q;
  assign done    = (state_q == SQ_DONE);

endmodule

// File: rtl/march_port_drv.sv
module march_port_drv #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              op_wr,
  input  logic              op_ones,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  logic              we_q, re_q, we_n, re_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, data_n;
  logic              rw_en, data_en, addr_en;

  always_comb begin
    rw_en   = issue || we_q || re_q;
    we_n    = issue && op_wr;
    re_n    = issue && !op_wr;
    data_en = issue;
    data_n  = op_ones ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
    addr_en = issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b0;
      re_q <= 1'b0;
    end else if (rw_en) begin
      we_q <= we_n;
      re_q <= re_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= op_addr;
  end

  assign mem_we    = we_q;
  assign mem_re    = re_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

endmodule

// File: rtl/march_fault_cmp.sv
module march_fault_cmp #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_strobe,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_exp,
  input  logic [DATA_W-1:0] rd_data,
  output logic              fault,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [DATA_W-1:0] fault_exp
);

  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_exp_q;
  logic              mismatch;
  logic              flt_q;
  logic [ADDR_W-1:0] flt_addr_q;
  logic [DATA_W-1:0] flt_exp_q;

  always_comb begin
    mismatch = pend_q && (rd_data != pend_exp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= rd_strobe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr_q <= '0;
      pend_exp_q  <= '0;
    end else if (rd_strobe) begin
      pend_addr_q <= rd_addr;
      pend_exp_q  <= rd_exp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flt_q <= 1'b0;
    else        flt_q <= mismatch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_addr_q <= '0;
      flt_exp_q  <= '0;
    end else if (mismatch) begin
      flt_addr_q <= pend_addr_q;
      flt_exp_q  <= pend_exp_q;
    end
  end

  assign fault      = flt_q;
  assign fault_addr = flt_addr_q;
  assign fault_exp  = flt_exp_q;

endmodule

// File: rtl/march_bist_ctrl.sv
module march_bist_ctrl
  import march_bist_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PROG_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [DATA_W-1:0] fault_exp
);

  localparam int unsigned IPW = $clog2(PROG_DEPTH);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [IPW-1:0]    fetch_addr;
  uword_t            fetch_word;
  logic              issue, op_wr, op_ones;
  logic [ADDR_W-1:0] op_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  march_ucode_store #(.IPW(IPW)) u_store (
    .rd_addr (fetch_addr),
    .rd_word (fetch_word)
  );

  march_seq #(.ADDR_W(ADDR_W), .IPW(IPW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .fetch_addr (fetch_addr),
    .fetch_word (fetch_word),
    .issue      (issue),
    .op_wr      (op_wr),
    .op_ones    (op_ones),
    .op_addr    (op_addr),
    .done       (done)
  );

  march_port_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .issue     (issue),
    .op_wr     (op_wr),
    .op_ones   (op_ones),
    .op_addr   (op_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  march_fault_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rd_strobe  (mem_re),
    .rd_addr    (mem_addr),
    .rd_exp     (mem_wdata),
    .rd_data    (mem_rdata),
    .fault      (fault),
    .fault_addr (fault_addr),
    .fault_exp  (fault_exp)
  );

endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              done,
  input logic              fault,
  input logic [ADDR_W-1:0] fault_addr,
  input logic [DATA_W-1:0] fault_exp
);

  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  // R9
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R8
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!mem_we && !mem_re));

  // R6
  fault_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($past(mem_re, 2) && (fault_addr == $past(mem_addr, 2))
               && (fault_exp == $past(mem_wdata, 2))));

  // R5
  solid_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> ((mem_wdata == '0) || (mem_wdata == {DATA_W{1'b1}})));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_we || mem_re) && $past(mem_we || mem_re)) |->
      ((mem_addr == $past(mem_addr)) || (mem_addr == $past(mem_addr) + 1'b1)
       || (mem_addr == $past(mem_addr) - 1'b1) || (mem_addr == '0)
       || (mem_addr == TOP)));

endmodule

bind march_bist_ctrl march_bist_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .done       (done),
  .fault      (fault),
  .fault_addr (fault_addr),
  .fault_exp  (fault_exp)
);

// File: tb/march_bist_ctrl_tb.sv
module march_bist_ctrl_tb;

  localparam int PERIOD = 10;
  localparam int AW     = 4;
  localparam int DW     = 8;
  localparam int NLOC   = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mem_we, mem_re, done, fault;
  logic [AW-1:0] mem_addr, fault_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, fault_exp;

  always #(PERIOD/2) clk = ~clk;

  march_bist_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .fault_addr(fault_addr), .fault_exp(fault_exp)
  );

  // RAM model with one injectable faulty word
  logic [DW-1:0] ram [NLOC];
  logic [DW-1:0] rd_q;
  logic [AW-1:0] bad_addr;
  logic [DW-1:0] sa1_mask, sa0_mask;
  logic          inj_on;

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) begin
      if (inj_on && mem_addr == bad_addr)
        rd_q <= (ram[mem_addr] & ~sa0_mask) | sa1_mask;
      else
        rd_q <= ram[mem_addr];
    end
  end
  assign mem_rdata = rd_q;

  // Reference access list
  logic          ex_w [512];
  logic [AW-1:0] ex_a [512];
  logic [DW-1:0] ex_d [512];
  int            ex_n;

  task automatic add_elem(input bit down, input int n, input logic [9:0] ops);
    for (int loc = 0; loc < NLOC; loc++) begin
      for (int k = 0; k < n; k++) begin
        ex_w[ex_n] = ops[2*k+1];
        ex_a[ex_n] = down ? AW'(NLOC - 1 - loc) : AW'(loc);
        ex_d[ex_n] = ops[2*k] ? {DW{1'b1}} : {DW{1'b0}};
        ex_n++;
      end
    end
  endtask

  // Monitors
  int errors = 0, checks = 0;
  int cyc, idx, seq_err, gaps, nw, nr, after_done, first_cyc, done_cyc;
  int nf, fbad, lat_err;
  logic          done_prev, h1_re, h2_re;
  logic [AW-1:0] h1_a, h2_a, xf_addr;
  logic [DW-1:0] xf_exp;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (fault) begin
        nf++;
        if (fault_addr != xf_addr || fault_exp != xf_exp) fbad++;
        if (!(h2_re && h2_a == fault_addr)) lat_err++;
      end
      if (mem_we || mem_re) begin
        if (done_prev) after_done++;
        if (idx == 0) first_cyc = cyc;
        if ((mem_we && mem_re) || idx >= ex_n || mem_we != ex_w[idx]
            || mem_addr != ex_a[idx] || mem_wdata != ex_d[idx])
          seq_err++;
        if (mem_we) nw++; else nr++;
        idx++;
      end else if (idx > 0 && idx < ex_n) begin
        gaps++;
      end
      if (done && !done_prev) done_cyc = cyc;
      done_prev = done;
      h2_re = h1_re; h2_a = h1_a;
      h1_re = mem_re; h1_a = mem_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    idx = 0; seq_err = 0; gaps = 0; nw = 0; nr = 0; after_done = 0;
    first_cyc = -1; done_cyc = -1; nf = 0; fbad = 0; lat_err = 0;
    done_prev = 1'b0; h1_re = 1'b0; h2_re = 1'b0; h1_a = '0; h2_a = '0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    clear_mon();
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk(done, "R8", "done reached", done, 1);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset_state();
    apply_reset();
    // R1
    chk(!mem_we && !mem_re, "R1", "strobes in reset", {mem_we, mem_re}, 0);
    chk(mem_addr == 0 && mem_wdata == 0, "R1", "addr/data in reset",
        {mem_addr, mem_wdata}, 0);
    chk(!done && !fault && fault_addr == 0 && fault_exp == 0, "R1",
        "done/fault in reset", {done, fault, fault_addr, fault_exp}, 0);
  endtask

  task automatic t_clean_run();
    inj_on = 1'b0;
    apply_reset();
    rst_n = 1'b1;
    wait_done();
    chk(first_cyc == 4, "R1", "first access edge", first_cyc, 4);
    chk(seq_err == 0, "R2", "access list mismatches", seq_err, 0);
    chk(gaps == 0, "R3", "idle cycles within run", gaps, 0);
    chk(idx == ex_n, "R3", "total accesses", idx, ex_n);
    chk(nw == 144, "R5", "write count", nw, 144);
    chk(nr == 208, "R4", "read count", nr, 208);
    chk(nf == 0, "R7", "fault pulses on good RAM", nf, 0);
    chk(done_cyc == first_cyc + ex_n - 1, "R8", "done edge", done_cyc,
        first_cyc + ex_n - 1);
    chk(after_done == 0, "R8", "accesses after done", after_done, 0);
  endtask

  task automatic t_stuck_one();
    inj_on = 1'b1; bad_addr = 4'd5; sa1_mask = 8'h08; sa0_mask = 8'h00;
    xf_addr = 4'd5; xf_exp = 8'h00;
    apply_reset();
    rst_n = 1'b1;
    wait_done();
    chk(nf == 7, "R6", "pulses for stuck-at-1", nf, 7);
    chk(fbad == 0, "R6", "pulse addr/exp errors", fbad, 0);
    chk(lat_err == 0, "R10", "pulse latency errors", lat_err, 0);
    chk(seq_err == 0, "R2", "access list under fault", seq_err, 0);
  endtask

  task automatic t_stuck_zero_top();
    inj_on = 1'b1; bad_addr = 4'd15; sa1_mask = 8'h00; sa0_mask = 8'h01;
    xf_addr = 4'd15; xf_exp = 8'hFF;
    apply_reset();
    rst_n = 1'b1;
    wait_done();
    chk(nf == 6, "R6", "pulses for stuck-at-0 at top", nf, 6);
    chk(fbad == 0, "R6", "pulse addr/exp errors at top", fbad, 0);
    chk(lat_err == 0, "R10", "pulse latency at top", lat_err, 0);
  endtask

  task automatic t_mid_reset();
    inj_on = 1'b0;
    apply_reset();
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!mem_we && !mem_re && mem_addr == 0 && !done, "R1",
        "outputs after mid-run reset", {mem_we, mem_re, mem_addr, done}, 0);
    clear_mon();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wait_done();
    chk(first_cyc == 4, "R1", "restart edge", first_cyc, 4);
    chk(seq_err == 0 && idx == ex_n, "R3", "restart full list", seq_err, 0);
  endtask

  initial begin
    ex_n = 0;
    inj_on = 1'b0; bad_addr = '0; sa1_mask = '0; sa0_mask = '0;
    xf_addr = '0; xf_exp = '0;
    for (int i = 0; i < NLOC; i++) ram[i] = 8'h5A;
    rd_q = '0;
    clear_mon();
    // ops packed two bits each {write, ones}, first op in the low bits
    add_elem(1'b0, 1, 10'b00_00_00_00_10);
    add_elem(1'b0, 5, 10'b11_00_10_00_00);
    add_elem(1'b0, 5, 10'b10_01_11_01_01);
    add_elem(1'b1, 5, 10'b11_00_10_00_00);
    add_elem(1'b1, 5, 10'b10_01_11_01_01);
    add_elem(1'b0, 1, 10'b00_00_00_00_00);
    t_reset_state();
    t_clean_run();
    t_stuck_one();
    t_stuck_zero_top();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule